// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the external memory bus of a small 8-bit controller. A phase counter splits every machine cycle into twelve oscillator periods. Each machine cycle is either a code fetch or an external data move. For each kind the block drives the address latch pulse, the active-low program read strobe, and the active-low data read and write strobes. It also drives the upper address byte on the high port and the multiplexed lower address and data byte on the low port.

The external-access pin is captured while reset is held. That captured value, together with the program counter, decides whether a fetch is served from internal code memory (no program strobe) or from the external bus. A software-controlled quiet bit can stop the address latch pulse so that an external latch stays still. The pulse is kept whenever the bus is really in use, and its resting level follows the idle and power-down state.

Data moves come in on a valid/ready request channel. `mv_ready` is high only in the last phase of a machine cycle. A request is taken on the clock edge where both `mv_valid` and `mv_ready` are high, and the next machine cycle becomes its data cycle. A requester that holds `mv_valid` without seeing ready waits at most one machine cycle, and must keep `mv_write`, `mv_addr` and `mv_wdata` steady until the transfer. Read data comes back on `rd_data` qualified by `rd_valid`. That return channel has no back-pressure: the consumer must take it in the phase it is shown.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset the phase counter starts at 0, advances by one each clock and wraps from 11 to 0. In a fetch cycle with no quiet suppression, `ale` is high exactly in phases 0 and 6.
- R2: In an external fetch cycle, `psen_n` is low in phases 2 to 4 and 8 to 10 and high in every other phase. In an internal fetch cycle it stays high.
- R3: `ea_pin` is captured only while `rst_n` is low. If it was captured high, a fetch is external exactly when the program counter sampled in phase 11 of the previous cycle is 0x8000 or above. If it was captured low, every fetch is external.
- R4: `mv_ready` is high only in phase 11. A request taken there makes the following machine cycle a data cycle that uses the address, direction and write data latched at that edge.
- R5: In a data cycle `psen_n` stays high throughout, and `ale` pulses only in phase 0 (the phase-6 pulse is dropped).
- R6: In a write data cycle, `wr_n` is low in phases 6 to 11 and the low port drives the write data with `lo_oe` high. `rd_n` stays high.
- R7: In a read data cycle, `rd_n` is low in phases 6 to 11 and `lo_oe` is low in those phases. `rd_valid` is high in phase 11 with `rd_data` equal to `lo_in`.
- R8: `hi_out` carries bits 15:8 of the cycle address (the program counter for fetches, `mv_addr` for data cycles). `lo_out` carries bits 7:0 with `lo_oe` high in phases 0 to 5 of a data cycle, and in phases 0, 1, 6 and 7 of an external fetch cycle.
- R9: `cfg_we` loads `cfg_quiet` into the quiet bit. With quiet set and the access pin captured high, an internal fetch cycle holds `ale` low when neither idle nor power-down is active.
- R10: With quiet set, `ale` still follows R1 and R5 in data cycles and in external fetch cycles. If the access pin was captured low, the quiet bit has no effect on `ale`.
- R11: With quiet set and the access pin captured high, power-down forces `ale` low, and otherwise idle forces it high, in every cycle kind.
- R12: While reset is held, `psen_n`, `rd_n` and `wr_n` are high and `lo_oe` is low. Reset clears the quiet bit. The first machine cycle after reset is an internal fetch with normal `ale` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| ea_pin | input | 1 | External-access strap, captured during reset |
| pc | input | 16 | Program counter for the next fetch |
| mv_valid | input | 1 | Data move request valid |
| mv_ready | output | 1 | Data move request accepted this cycle |
| mv_write | input | 1 | Move direction: 1 write, 0 read |
| mv_addr | input | 16 | Data move address |
| mv_wdata | input | 8 | Data move write byte |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 8 | Read data from the low port |
| cfg_we | input | 1 | Load strobe for the quiet bit |
| cfg_quiet | input | 1 | New value of the quiet bit |
| idle | input | 1 | Core is in idle |
| pdown | input | 1 | Core is in power-down |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| hi_out | output | 8 | High address port |
| lo_out | output | 8 | Low address/data port output value |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value |

## Verification
The assertions check, on every clock, the rules that hold in any state. The phase counter steps and wraps. Cycle kind and high address only change at the machine-cycle boundary. An accepted request always yields a data cycle. The read and write strobes never overlap, and the program strobe stays high during a data strobe. The low port is released while reading. Power-down keeps a quiet `ale` low, and an internal quiet fetch suppresses it. What needs the bench's scenarios is the exact phase map of each strobe per cycle kind, the fetch location chosen from the access strap and the program counter, and the full quiet-mode table over idle, power-down and cycle kind. The bench sweeps all of these over each captured strap value.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH_INT = 2'd0,
    KIND_FETCH_EXT = 2'd1,
    KIND_DATA_RD   = 2'd2,
    KIND_DATA_WR   = 2'd3
  } ebs_kind_e;
endpackage

// File: rtl/ebs_phase.sv
module ebs_phase #(
  parameter int PHASES = 12,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] LAST_P = PW'(PHASES - 1);

  assign last = (phase == LAST_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (last) phase <= '0;
    else phase <= phase + 1'b1;
  end

  // R1: wrap at the end of the machine cycle
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (phase == '0));
  // R1: single step inside the machine cycle
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> (phase == PW'($past(phase) + 1'b1)));
endmodule

// File: rtl/ebs_cycle_ctl.sv
module ebs_cycle_ctl
  import ebs_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int INT_SIZE = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ea_pin,
  input  logic [AW-1:0] pc,
  input  logic          last,
  input  logic          mv_valid,
  input  logic          mv_write,
  input  logic [AW-1:0] mv_addr,
  input  logic [DW-1:0] mv_wdata,
  input  logic          cfg_we,
  input  logic          cfg_quiet,
  output logic          mv_ready,
  output ebs_kind_e     kind,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_wdata,
  output logic          ea_int,
  output logic          quiet
);
  ebs_kind_e next_kind;
  logic      pc_beyond;

  assign mv_ready  = last;
  assign pc_beyond = (32'(pc) >= INT_SIZE);

  // strap capture: only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) ea_int <= ea_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet <= 1'b0;
    else if (cfg_we) quiet <= cfg_quiet;
  end

  always_comb begin
    if (mv_valid) next_kind = mv_write ? KIND_DATA_WR : KIND_DATA_RD;
    else if (!ea_int || pc_beyond) next_kind = KIND_FETCH_EXT;
    else next_kind = KIND_FETCH_INT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= KIND_FETCH_INT;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
    end else if (last) begin
      kind      <= next_kind;
      cyc_addr  <= mv_valid ? mv_addr : pc;
      cyc_wdata <= mv_wdata;
    end
  end

  // R4: an accepted request turns the next cycle into a data cycle
  assert_accept_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready) |=> (kind == KIND_DATA_RD || kind == KIND_DATA_WR));
  // R4: cycle kind only changes at the cycle boundary
  assert_kind_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(kind));
  // R3: strap captured low forces external fetches
  assert_ea_low_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !mv_valid && !ea_int) |=> (kind == KIND_FETCH_EXT));
  // R9: quiet bit only moves on a load strobe
  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(quiet));
endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
  import ebs_pkg::*;
#(
  parameter int PHASES = 12,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  ebs_kind_e     kind,
  input  logic          quiet,
  input  logic          ea_int,
  input  logic          idle,
  input  logic          pdown,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          rd_valid
);
  localparam int HALF = PHASES / 2;
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam logic [PW-1:0] LAST_P = PW'(PHASES - 1);

  logic       is_data;
  logic       second_half;
  logic       ale_base;
  logic       quiet_eff;
  logic [1:0] fetch_win;

  assign is_data     = (kind == KIND_DATA_RD) || (kind == KIND_DATA_WR);
  assign second_half = (phase >= HALF_P);

  // one program strobe window after each latch pulse
  for (genvar h = 0; h < 2; h++) begin : g_win
    assign fetch_win[h] = (phase >= PW'(h * HALF + 2)) &&
                          (phase <= PW'(h * HALF + HALF - 2));
  end

  assign ale_base = is_data ? (phase == '0) : ((phase == '0) || (phase == HALF_P));
  assign quiet_eff = quiet && ea_int;

  always_comb begin
    if (!quiet_eff) ale = ale_base;
    else if (pdown) ale = 1'b0;
    else if (idle) ale = 1'b1;
    else if (is_data || kind == KIND_FETCH_EXT) ale = ale_base;
    else ale = 1'b0;
  end

  assign psen_n   = !((kind == KIND_FETCH_EXT) && (|fetch_win));
  assign rd_n     = !((kind == KIND_DATA_RD) && second_half);
  assign wr_n     = !((kind == KIND_DATA_WR) && second_half);
  assign rd_valid = (kind == KIND_DATA_RD) && (phase == LAST_P);

  // R6: read and write strobes never overlap
  assert_rdwr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n);
  // R5: no program strobe while a data strobe is active
  assert_psen_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> psen_n);
  // R11: power-down keeps a quiet latch pulse low
  assert_quiet_pdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ea_int && pdown) |-> !ale);
  // R9: quiet internal fetch suppresses the pulse
  assert_quiet_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ea_int && !idle && !pdown && kind == KIND_FETCH_INT) |-> !ale);
  // R10: strap low ignores the quiet bit
  assert_ea_low_ale_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ea_int && phase == '0) |-> ale);
endmodule

// File: rtl/ebs_bus_mux.sv
module ebs_bus_mux
  import ebs_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int PHASES = 12,
  localparam int PW = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    phase,
  input  ebs_kind_e        kind,
  input  logic [AW-1:0]    cyc_addr,
  input  logic [DW-1:0]    cyc_wdata,
  output logic [AW-DW-1:0] hi_out,
  output logic [DW-1:0]    lo_out,
  output logic             lo_oe
);
  localparam int HALF = PHASES / 2;
  localparam logic [PW-1:0] HALF_P = PW'(HALF);

  logic first_half;
  logic ext_addr_slot;

  assign hi_out     = cyc_addr[AW-1:DW];
  assign first_half = (phase < HALF_P);
  assign ext_addr_slot = (phase == '0) || (phase == PW'(1)) ||
                         (phase == HALF_P) || (phase == PW'(HALF + 1));

  always_comb begin
    lo_out = cyc_addr[DW-1:0];
    lo_oe  = 1'b0;
    unique case (kind)
      KIND_FETCH_INT: lo_oe = 1'b0;
      KIND_FETCH_EXT: lo_oe = ext_addr_slot;
      KIND_DATA_RD:   lo_oe = first_half;
      KIND_DATA_WR: begin
        lo_oe = 1'b1;
        if (!first_half) lo_out = cyc_wdata;
      end
      default: lo_oe = 1'b0;
    endcase
  end

  // R8: the high address only moves at the machine-cycle boundary
  assert_hi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> $stable(hi_out));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int PHASES   = 12,
  parameter int INT_SIZE = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ea_pin,
  input  logic [AW-1:0]    pc,
  input  logic             mv_valid,
  output logic             mv_ready,
  input  logic             mv_write,
  input  logic [AW-1:0]    mv_addr,
  input  logic [DW-1:0]    mv_wdata,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic             cfg_we,
  input  logic             cfg_quiet,
  input  logic             idle,
  input  logic             pdown,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [AW-DW-1:0] hi_out,
  output logic [DW-1:0]    lo_out,
  output logic             lo_oe,
  input  logic [DW-1:0]    lo_in
);
  localparam int PW = $clog2(PHASES);

  logic [PW-1:0] phase;
  logic          last;
  ebs_kind_e     kind;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_wdata;
  logic          ea_int;
  logic          quiet;

  ebs_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last)
  );

  ebs_cycle_ctl #(.AW(AW), .DW(DW), .INT_SIZE(INT_SIZE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .pc(pc), .last(last),
    .mv_valid(mv_valid), .mv_write(mv_write), .mv_addr(mv_addr),
    .mv_wdata(mv_wdata), .cfg_we(cfg_we), .cfg_quiet(cfg_quiet),
    .mv_ready(mv_ready), .kind(kind), .cyc_addr(cyc_addr),
    .cyc_wdata(cyc_wdata), .ea_int(ea_int), .quiet(quiet)
  );

  ebs_strobe_gen #(.PHASES(PHASES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind), .quiet(quiet),
    .ea_int(ea_int), .idle(idle), .pdown(pdown), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .rd_valid(rd_valid)
  );

  ebs_bus_mux #(.AW(AW), .DW(DW), .PHASES(PHASES)) u_mux (
    .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .hi_out(hi_out), .lo_out(lo_out), .lo_oe(lo_oe)
  );

  assign rd_data = lo_in;

  // R7: the low port is released whenever the read strobe is low
  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);
endmodule

// File: tb/sim_ext_bus_seq.sv
`timescale 1ns/1ps
module sim_ext_bus_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, ea_pin = 1'b1;
  logic [15:0] pc = '0, mv_addr = '0;
  logic        mv_valid = 0, mv_write = 0, cfg_we = 0, cfg_quiet = 0;
  logic        idle = 0, pdown = 0;
  logic [7:0]  mv_wdata = '0, lo_in = '0;
  logic        mv_ready, rd_valid, ale, psen_n, rd_n, wr_n, lo_oe;
  logic [7:0]  rd_data, hi_out, lo_out;

  int total = 0, bad = 0, bp = 0;
  bit ea_cap = 1, q_now = 0, finished = 0;

  ext_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .pc(pc),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_write(mv_write),
    .mv_addr(mv_addr), .mv_wdata(mv_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .cfg_we(cfg_we), .cfg_quiet(cfg_quiet),
    .idle(idle), .pdown(pdown), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .hi_out(hi_out), .lo_out(lo_out),
    .lo_oe(lo_oe), .lo_in(lo_in)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s phase=%0d actual=%0h expected=%0h", req, what, bp, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    bp = (bp + 1) % 12;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit ea);
    @(negedge clk);
    rst_n = 1'b0; ea_pin = ea; cfg_we = 0; mv_valid = 0;
    idle = 0; pdown = 0; pc = '0;
    repeat (3) @(negedge clk);
    chk("R12", "psen_n in reset", psen_n, 1);
    chk("R12", "rd_n in reset", rd_n, 1);
    chk("R12", "wr_n in reset", wr_n, 1);
    chk("R12", "lo_oe in reset", lo_oe, 0);
    rst_n = 1'b1; bp = 0; ea_cap = ea; q_now = 0;
    for (int p = 0; p < 12; p++) begin
      // R12: quiet cleared, first cycle is internal fetch; R1 phase map
      chk("R12", "ale first cycle", ale, (p == 0 || p == 6));
      chk("R12", "psen_n first cycle", psen_n, 1);
      chk("R1", "ready map", mv_ready, (p == 11));
      if (p < 11) step();
    end
  endtask

  // called at the negedge of phase 11; returns at the next phase 11
  task automatic do_cycle(input bit data, input bit wr, input logic [15:0] addr,
                          input logic [7:0] wd, input logic [15:0] pcv,
                          input bit q, input bit idl, input bit pd);
    bit ext, qe, oe_e, ale_e;
    string atag;
    chk("R4", "ready at phase 11", mv_ready, 1);
    pc = pcv; mv_valid = data; mv_write = wr; mv_addr = addr; mv_wdata = wd;
    idle = idl; pdown = pd; lo_in = addr[7:0] ^ 8'h5A;
    if (q != q_now) begin cfg_we = 1; cfg_quiet = q; q_now = q; end
    step();
    cfg_we = 0; mv_valid = 0; mv_addr = ~addr; mv_wdata = ~wd; mv_write = ~wr;
    ext = !ea_cap || (pcv >= 16'h8000);
    qe  = q && ea_cap;
    if (q && !ea_cap) atag = "R10";
    else if (qe && (pd || idl)) atag = "R11";
    else if (qe) atag = (data || ext) ? "R10" : "R9";
    else atag = data ? "R5" : "R1";
    for (int p = 0; p < 12; p++) begin
      ale_e = data ? (p == 0) : (p == 0 || p == 6);
      if (qe) begin
        if (pd) ale_e = 0;
        else if (idl) ale_e = 1;
        else if (!(data || ext)) ale_e = 0;
      end
      chk(atag, "ale", ale, ale_e);
      chk(data ? "R5" : "R2 R3", "psen_n", psen_n,
          !(!data && ext && ((p >= 2 && p <= 4) || (p >= 8 && p <= 10))));
      chk("R6", "wr_n", wr_n, !(data && wr && p >= 6));
      chk("R7", "rd_n", rd_n, !(data && !wr && p >= 6));
      oe_e = data ? (p < 6 || wr) : (ext && (p == 0 || p == 1 || p == 6 || p == 7));
      chk((data && !wr && p >= 6) ? "R7" : "R8", "lo_oe", lo_oe, oe_e);
      if (oe_e)
        chk(data && p >= 6 ? "R6" : "R8", "lo_out", lo_out,
            data ? (p < 6 ? addr[7:0] : wd) : pcv[7:0]);
      chk("R8", "hi_out", hi_out, data ? addr[15:8] : pcv[15:8]);
      chk("R7", "rd_valid", rd_valid, (data && !wr && p == 11));
      if (data && !wr && p == 11) chk("R7", "rd_data", rd_data, addr[7:0] ^ 8'h5A);
      chk("R4", "ready map", mv_ready, (p == 11));
      if (p < 11) step();
    end
  endtask

  initial begin
    logic [15:0] pcs [5];
    logic [15:0] adrs [4];
    bit eas [3];
    pcs  = '{16'h0000, 16'h1234, 16'h7FFF, 16'h8000, 16'hFFFF};
    adrs = '{16'h0000, 16'h80FF, 16'h7F01, 16'hFFFF};
    eas  = '{1'b1, 1'b0, 1'b1};
    for (int e = 0; e < 3; e++) begin
      do_reset(eas[e]);
      for (int i = 0; i < 5; i++)
        for (int q = 0; q < 2; q++)
          for (int m = 0; m < 4; m++)
            do_cycle(0, 0, 16'h0, 8'h0, pcs[i], q[0], m[0], m[1]);
      for (int w = 0; w < 2; w++)
        for (int q = 0; q < 2; q++)
          for (int a = 0; a < 4; a++)
            do_cycle(1, w[0], adrs[a], adrs[a][7:0] + 8'h11, 16'h0100, q[0], 0, 0);
      // leave quiet set so the next reset shows it cleared
      do_cycle(0, 0, 16'h0, 8'h0, 16'h0010, 1, 0, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule